// File: doc/BRIEF.md
# Fractional-Increment Nanosecond Time-of-Day Counter

This block keeps a free-running 64-bit count of nanoseconds for precision time-stamping logic. On every enabled clock cycle it adds a programmable fixed-point increment. The increment has 32 integer and 32 fractional nanosecond bits. A 32-bit fraction accumulator holds the sub-nanosecond remainder, and its carry is added to the nanosecond count. Because the count is 64 bits wide, no separate cycle counter is needed. The current value is driven on a wide output so that capture logic can take stamps directly.

Software reaches the counter through a 32-bit register port with single-cycle write and read strobes. Wide values move as two halves. A read of the low time word freezes a snapshot of the whole count, and a later read of the high word returns the upper half of that snapshot. A write of a low word (time, increment or step delta) is held pending until the matching high word is written, and then the whole 64-bit value takes effect at once. The increment can be changed to trim frequency or to follow a new link rate, for example 0x01_9999_9999 for 1.6 ns per cycle, 0x03_3333_3333 for 3.2 ns or 0x20_0000_0000 for 32 ns. An increment of zero freezes the clock.

Top module: `ptp_tod_counter`

## Requirements
- R1: After reset the time and fraction are zero, the enable is clear, and the active increment equals the RESET_INC parameter.
- R2: While enabled, each cycle adds the upper 32 increment bits plus the carry out of (fraction + lower 32 increment bits) to the time. The fraction keeps the 32-bit sum, and the time wraps modulo 2^64.
- R3: Bit 0 of the control word (address 0) is the count enable. While it is clear, the time and the fraction hold.
- R4: A write to address 1 (time low) only stores a pending value. A write to address 2 (time high) loads {written data, pending low} into the time, clears the fraction and discards that cycle's increment, so time_o equals the written value on the next cycle.
- R5: A read of address 1 returns time bits 31:0 and snapshots all 64 bits. A read of address 2 returns bits 63:32 of the latest snapshot, even if the time has moved on since.
- R6: A write to address 3 (increment low) is pending only. A write to address 4 (increment high) makes {written data, pending low} the active increment from the next cycle on. Reads of addresses 3 and 4 return the active increment's low and high halves.
- R7: An active increment of zero keeps the time constant while enabled.
- R8: Writes to address 5 (step low, pending) and then address 6 (step high) add the two's-complement 64-bit delta {high, low} to the time, together with that cycle's normal increment.
- R9: Read data appears on rdata_o with rvalid_o high in the cycle after rd_i. Reads of addresses 5, 6 and 7 return zero, and reads of address 0 return the enable in bit 0 with zeros above it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| rvalid_o | output | 1 | Read data valid, one cycle after rd_i |
| time_o | output | 64 | Current nanosecond time |

## Verification
The bench builds the block with its default parameters: a 32-bit register word, a 64-bit time and a reset increment of 0x01_9999_9999. With 32 fraction bits, runs of a hundred cycles at the 1.6 ns and 3.2 ns rates produce fraction carries that a reference model checks exactly. Loading times just below a 2^32 boundary and at 2^64 - 1 exercises the carry between the two halves, the snapshot coherence across that boundary, and the wrap of the full count.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned TIME_W = 2 * DATA_W;
  localparam int unsigned FRAC_W = DATA_W;
  localparam int unsigned INT_W  = DATA_W;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL    = 3'd0,
    REG_TIME_LO = 3'd1,
    REG_TIME_HI = 3'd2,
    REG_INC_LO  = 3'd3,
    REG_INC_HI  = 3'd4,
    REG_STEP_LO = 3'd5,
    REG_STEP_HI = 3'd6
  } reg_sel_e;

  typedef struct packed {
    logic              load;
    logic              step;
    logic [TIME_W-1:0] value;
  } time_cmd_t;
endpackage

// File: rtl/ptp_reg_ctrl.sv
module ptp_reg_ctrl
  import ptp_tod_pkg::*;
#(
  parameter logic [TIME_W-1:0] RESET_INC = 64'h0000_0001_9999_9999
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              en_o,
  output logic [INT_W-1:0]  inc_int_o,
  output logic [FRAC_W-1:0] inc_frac_o,
  output logic [DATA_W-1:0] pend_time_lo_o,
  output time_cmd_t         cmd_o
);
  logic              en_q;
  logic [TIME_W-1:0] inc_q;
  logic [DATA_W-1:0] pend_time_q, pend_inc_q, pend_step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q        <= 1'b0;
      inc_q       <= RESET_INC;
      pend_time_q <= '0;
      pend_inc_q  <= '0;
      pend_step_q <= '0;
    end else if (wr_i) begin
      unique case (addr_i)
        REG_CTRL:    en_q        <= wdata_i[0];
        REG_TIME_LO: pend_time_q <= wdata_i;
        REG_INC_LO:  pend_inc_q  <= wdata_i;
        REG_INC_HI:  inc_q       <= {wdata_i, pend_inc_q};
        REG_STEP_LO: pend_step_q <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    cmd_o       = '0;
    cmd_o.load  = wr_i && (addr_i == REG_TIME_HI);
    cmd_o.step  = wr_i && (addr_i == REG_STEP_HI);
    cmd_o.value = cmd_o.step ? {wdata_i, pend_step_q} : {wdata_i, pend_time_q};
  end

  assign en_o           = en_q;
  assign inc_int_o      = inc_q[TIME_W-1:FRAC_W];
  assign inc_frac_o     = inc_q[FRAC_W-1:0];
  assign pend_time_lo_o = pend_time_q;
endmodule

// File: rtl/ptp_time_accum.sv
module ptp_time_accum
  import ptp_tod_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [INT_W-1:0]  inc_int_i,
  input  logic [FRAC_W-1:0] inc_frac_i,
  input  time_cmd_t         cmd_i,
  output logic [TIME_W-1:0] time_o
);
  logic [TIME_W-1:0] ns_q;
  logic [FRAC_W-1:0] frac_q;
  logic [FRAC_W:0]   frac_sum;
  logic [TIME_W-1:0] tick_add, step_add;

  always_comb begin
    frac_sum = {1'b0, frac_q} + (en_i ? {1'b0, inc_frac_i} : '0);
    tick_add = en_i ? (TIME_W'(inc_int_i) + TIME_W'(frac_sum[FRAC_W])) : '0;
    step_add = cmd_i.step ? cmd_i.value : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ns_q   <= '0;
      frac_q <= '0;
    end else if (cmd_i.load) begin
      // Load wins over the tick: that cycle's increment is dropped
      ns_q   <= cmd_i.value;
      frac_q <= '0;
    end else begin
      ns_q   <= ns_q + tick_add + step_add;
      frac_q <= frac_sum[FRAC_W-1:0];
    end
  end

  assign time_o = ns_q;
endmodule

// File: rtl/ptp_rd_port.sv
module ptp_rd_port
  import ptp_tod_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [TIME_W-1:0] time_i,
  input  logic              en_i,
  input  logic [INT_W-1:0]  inc_int_i,
  input  logic [FRAC_W-1:0] inc_frac_i,
  output logic [TIME_W-1:0] snap_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  logic [TIME_W-1:0] snap_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    unique case (addr_i)
      REG_CTRL:    rd_mux = DATA_W'(en_i);
      REG_TIME_LO: rd_mux = time_i[DATA_W-1:0];
      REG_TIME_HI: rd_mux = snap_q[TIME_W-1:DATA_W];
      REG_INC_LO:  rd_mux = inc_frac_i;
      REG_INC_HI:  rd_mux = inc_int_i;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q   <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_i;
      if (rd_i) rdata_q <= rd_mux;
      if (rd_i && addr_i == REG_TIME_LO) snap_q <= time_i;
    end
  end

  assign snap_o   = snap_q;
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter
  import ptp_tod_pkg::*;
#(
  parameter logic [TIME_W-1:0] RESET_INC = 64'h0000_0001_9999_9999
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic [TIME_W-1:0] time_o
);
  logic              en_w;
  logic [INT_W-1:0]  inc_int_w;
  logic [FRAC_W-1:0] inc_frac_w;
  logic [DATA_W-1:0] pend_time_lo_w;
  logic [TIME_W-1:0] snap_w;
  time_cmd_t         cmd_w;

  ptp_reg_ctrl #(.RESET_INC(RESET_INC)) u_ctrl (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .en_o(en_w), .inc_int_o(inc_int_w), .inc_frac_o(inc_frac_w),
    .pend_time_lo_o(pend_time_lo_w), .cmd_o(cmd_w)
  );

  ptp_time_accum u_accum (
    .clk_i, .rst_ni, .en_i(en_w), .inc_int_i(inc_int_w),
    .inc_frac_i(inc_frac_w), .cmd_i(cmd_w), .time_o
  );

  ptp_rd_port u_rd (
    .clk_i, .rst_ni, .rd_i, .addr_i, .time_i(time_o), .en_i(en_w),
    .inc_int_i(inc_int_w), .inc_frac_i(inc_frac_w),
    .snap_o(snap_w), .rdata_o, .rvalid_o
  );
endmodule

// File: rtl/ptp_tod_checker.sv
module ptp_tod_checker
  import ptp_tod_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic              rd_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [TIME_W-1:0] time_o,
  input logic              en_w,
  input logic [INT_W-1:0]  inc_int_w,
  input logic [FRAC_W-1:0] inc_frac_w,
  input logic [DATA_W-1:0] pend_time_lo_w,
  input logic [TIME_W-1:0] snap_w
);
  logic ld, st;
  assign ld = wr_i && addr_i == REG_TIME_HI;
  assign st = wr_i && addr_i == REG_STEP_HI;

  assert_load_value_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld |=> time_o == $past({wdata_i, pend_time_lo_w}));

  assert_hold_disabled_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_w && !ld && !st) |=> $stable(time_o));

  assert_zero_inc_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_int_w == '0 && inc_frac_w == '0 && !ld && !st) |=> $stable(time_o));

  assert_step_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_w && !ld && !st) |=>
      ((time_o - $past(time_o)) == TIME_W'($past(inc_int_w))) ||
      ((time_o - $past(time_o)) == TIME_W'($past(inc_int_w)) + 64'd1));

  assert_snapshot_hi_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == REG_TIME_HI) |=> rdata_o == $past(snap_w[TIME_W-1:DATA_W]));

  assert_inc_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == REG_INC_HI) |=> $stable({inc_int_w, inc_frac_w}));
endmodule

bind ptp_tod_counter ptp_tod_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .rd_i(rd_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .time_o(time_o), .en_w(en_w),
  .inc_int_w(inc_int_w), .inc_frac_w(inc_frac_w),
  .pend_time_lo_w(pend_time_lo_w), .snap_w(snap_w)
);

// File: tb/tb_ptp_tod_counter.sv
`timescale 1ns/1ps
module tb_ptp_tod_counter;
  localparam logic [63:0] RST_INC = 64'h0000_0001_9999_9999;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic [63:0] time_v;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R1 reset";

  always #2 clk = ~clk;

  ptp_tod_counter dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .time_o(time_v)
  );

  // Reference model and expected-item queue
  logic [63:0] m_ns, m_snap, m_inc;
  logic [31:0] m_frac, m_pt, m_pi, m_ps;
  logic        m_en;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ns = '0; m_snap = '0; m_inc = RST_INC; m_frac = '0;
      m_pt = '0; m_pi = '0; m_ps = '0; m_en = 1'b0;
    end else begin
      logic [32:0] fs;
      logic [63:0] add;
      logic [63:0] n_inc;
      logic        n_en;
      if (rd) begin
        logic [31:0] e;
        case (addr)
          3'd0: e = {31'b0, m_en};
          3'd1: e = m_ns[31:0];
          3'd2: e = m_snap[63:32];
          3'd3: e = m_inc[31:0];
          3'd4: e = m_inc[63:32];
          default: e = '0;
        endcase
        if (addr == 3'd1) m_snap = m_ns;
        exp_q.push_back(e);
        tag_q.push_back(cur_tag);
      end
      fs    = m_en ? ({1'b0, m_frac} + {1'b0, m_inc[31:0]}) : {1'b0, m_frac};
      add   = m_en ? ({32'b0, m_inc[63:32]} + {63'b0, fs[32]}) : 64'd0;
      n_inc = m_inc;
      n_en  = m_en;
      if (wr && addr == 3'd2) begin
        m_ns = {wdata, m_pt}; m_frac = '0;
      end else begin
        if (wr && addr == 3'd6) add = add + {wdata, m_ps};
        m_ns = m_ns + add; m_frac = fs[31:0];
      end
      if (wr) case (addr)
        3'd0: n_en = wdata[0];
        3'd1: m_pt = wdata;
        3'd3: m_pi = wdata;
        3'd4: n_inc = {wdata, m_pi};
        3'd5: m_ps = wdata;
        default: ;
      endcase
      m_en = n_en; m_inc = n_inc;
    end
  end

  // Monitor: pops expected items as read data appears
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R9 unexpected read data: got %h expected none", rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          errors++;
          $display("FAIL %s: got %h expected %h", t, rdata, e);
        end
      end
    end
  end

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, input string t);
    cur_tag = t; rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk64(input string t, input logic [63:0] act, input logic [63:0] e);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: got %h expected %h", t, act, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk64("R1 reset time_o", time_v, 64'd0);
    rreg(3'd0, "R1 reset ctrl");
    rreg(3'd3, "R1 reset inc lo");
    rreg(3'd4, "R1 reset inc hi");
    rreg(3'd1, "R1 reset time lo");
    idle(2);

    wreg(3'd0, 32'd1);
    idle(10);
    rreg(3'd1, "R2 count lo");
    rreg(3'd2, "R2 count hi");

    wreg(3'd1, 32'hFFFF_FFF0);
    wreg(3'd2, 32'h0000_0001);
    chk64("R4 load with tick", time_v, 64'h0000_0001_FFFF_FFF0);
    rreg(3'd1, "R4 after load lo");
    rreg(3'd2, "R4 after load hi");

    wreg(3'd1, 32'h0000_1234);
    idle(5);
    rreg(3'd1, "R4 low write pending");
    rreg(3'd2, "R4 low write pending hi");

    wreg(3'd3, 32'h0);
    wreg(3'd4, 32'h20);
    wreg(3'd1, 32'hFFFF_FF00);
    wreg(3'd2, 32'h2);
    rreg(3'd1, "R5 snapshot lo");
    idle(20);
    rreg(3'd2, "R5 snapshot hi across boundary");
    chk64("R5 time moved past snapshot", {32'b0, time_v[63:32]}, 64'd3);

    wreg(3'd3, 32'h3333_3333);
    idle(5);
    rreg(3'd3, "R6 inc low pending");
    rreg(3'd4, "R6 inc hi unchanged");
    wreg(3'd4, 32'h3);
    rreg(3'd3, "R6 inc lo committed");
    idle(100);
    rreg(3'd1, "R2 fraction carry 3.2ns lo");
    rreg(3'd2, "R2 fraction carry 3.2ns hi");

    wreg(3'd3, 32'h0);
    wreg(3'd4, 32'h0);
    rreg(3'd1, "R7 zero inc first");
    idle(10);
    rreg(3'd1, "R7 zero inc second");

    wreg(3'd3, 32'h9999_9999);
    wreg(3'd4, 32'h1);
    wreg(3'd0, 32'd0);
    rreg(3'd0, "R3 enable clear");
    rreg(3'd1, "R3 disabled first");
    idle(10);
    rreg(3'd1, "R3 disabled second");

    wreg(3'd0, 32'd1);
    idle(100);
    rreg(3'd1, "R2 fraction carry 1.6ns");
    wreg(3'd5, 32'hFFFF_FC18);
    wreg(3'd6, 32'hFFFF_FFFF);
    rreg(3'd1, "R8 negative step lo");
    rreg(3'd2, "R8 negative step hi");

    wreg(3'd1, 32'hFFFF_FFFF);
    wreg(3'd2, 32'hFFFF_FFFF);
    chk64("R4 load all ones", time_v, 64'hFFFF_FFFF_FFFF_FFFF);
    idle(3);
    rreg(3'd1, "R2 wrap lo");
    rreg(3'd2, "R2 wrap hi");

    rreg(3'd5, "R9 step lo reads zero");
    rreg(3'd6, "R9 step hi reads zero");
    rreg(3'd7, "R9 unmapped reads zero");
    idle(3);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R9 missing read data: got %0d left expected 0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule